// File: doc/BRIEF.md
# In-Place Bubble Sort Sequencer

This block sorts a run of signed words that already sit in a single-port synchronous RAM. The caller names the first address and the number of words and gives one start pulse. The sequencer then walks the run again and again. It compares each pair of neighbours and exchanges them when the lower-addressed word is strictly larger. When the run is in ascending signed order it gives a one-cycle completion pulse.

Each comparison step fetches only one word from memory. The other word of the pair is kept in a carry register inside the block. After a compare, that register holds the larger word of the pair, which is also the word that moves one position up. A run of zero or one words ends at once and touches nothing. The number of steps never depends on the data. Only the number of exchanges changes the total time, and this makes the run time easy to predict.

Top module: `bsort_engine`

## Requirements
- R1: After reset, `done_o` and `mem_we_o` are both 0.
- R2: When `done_o` pulses, the `len_i` words starting at `base_i` are in ascending order, read as two's-complement signed numbers of `DATA_W` bits.
- R3: Two neighbours are exchanged only when the lower one is strictly greater. An exchange writes the smaller word at the lower address in one cycle and the larger word at the next address in the following cycle, so a run is sorted with exactly two writes per inversion.
- R4: Each compare step reads memory once. With length n ≥ 2 and S inversions, `done_o` rises exactly n·2·(n−1) + 2·S clock edges after the edge that samples `start_i`.
- R5: A start with `len_i` of 0 or 1 gives `done_o` on the very next edge and makes no write.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: A `start_i` pulse that arrives while a sort is in progress has no effect. Timing, writes and result stay those of the first request.
- R8: No write lands outside the addresses from `base_i` to `base_i + len_i − 1`. Address arithmetic wraps modulo 2^`ADDR_W`.
- R9: A write cycle is never followed by more than one further write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| base_i | input | ADDR_W | Address of the first word of the run |
| len_i | input | LEN_W | Number of words in the run (0 to MAX_LEN) |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid one cycle after the address |

## Verification
The completion pulse is expected a number of edges after the sampled start that the bench works out from the length and the inversion count of the loaded data. The bench counts edges from the start edge and samples on falling edges. It flags a pulse that comes early or late, not only a missing one. The RAM model writes on the rising edge, and the bench checks its contents and its write count only after the pulse. The pulse itself is checked again one cycle later to confirm it has dropped.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WT,
        ST_RD,
        ST_CMP,
        ST_WR_LO,
        ST_WR_HI,
        ST_DONE
    } bsort_state_t;

endpackage

// File: rtl/bsort_cmp.sv
// Signed ordering of the carried word against the freshly fetched one.
module bsort_cmp #(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W-1:0] carry_i,
    input  logic signed [DATA_W-1:0] fetched_i,
    output logic                     swap_o,
    output logic signed [DATA_W-1:0] lo_o,
    output logic signed [DATA_W-1:0] hi_o
);
    always_comb begin
        swap_o = carry_i > fetched_i;
        lo_o   = swap_o ? fetched_i : carry_i;
        hi_o   = swap_o ? carry_i   : fetched_i;
    end
endmodule

// File: rtl/bsort_addr.sv
// Base plus element offset, wrapping within the address space.
module bsort_addr #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 9
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SUM_W = ADDR_W + LEN_W;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum    = {{LEN_W{1'b0}}, base_i} + {{ADDR_W{1'b0}}, offset_i};
        addr_o = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/bsort_ctrl.sv
// Pass / step sequencer, two-process style.
module bsort_ctrl
    import bsort_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [LEN_W-1:0]         len_i,
    input  logic signed [DATA_W-1:0] rdata_i,
    input  logic                     swap_i,
    input  logic signed [DATA_W-1:0] lo_i,
    input  logic signed [DATA_W-1:0] hi_i,
    output logic signed [DATA_W-1:0] carry_o,
    output logic [ADDR_W-1:0]        base_o,
    output logic [LEN_W-1:0]         offset_o,
    output logic                     we_o,
    output logic signed [DATA_W-1:0] wdata_o,
    output logic                     busy_o,
    output logic                     done_o
);
    localparam logic [LEN_W-1:0] L_ZERO = '0;
    localparam logic [LEN_W-1:0] L_ONE  = LEN_W'(1);

    typedef struct packed {
        bsort_state_t             st;
        logic [LEN_W-1:0]         len;
        logic [LEN_W-1:0]         pass;
        logic [LEN_W-1:0]         j;
        logic [ADDR_W-1:0]        base;
        logic signed [DATA_W-1:0] carry;
        logic signed [DATA_W-1:0] low;
    } regs_t;

    regs_t r_q, r_d;

    logic             last_step;
    logic             last_pass;
    logic [LEN_W-1:0] j_next;

    always_comb begin
        r_d       = r_q;
        offset_o  = L_ZERO;
        we_o      = 1'b0;
        wdata_o   = r_q.carry;
        j_next    = r_q.j + L_ONE;
        last_step = (j_next == r_q.len - L_ONE);
        last_pass = ((r_q.pass + L_ONE) == r_q.len - L_ONE);

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.len  = len_i;
                    r_d.base = base_i;
                    r_d.pass = L_ZERO;
                    r_d.j    = L_ZERO;
                    r_d.st   = (len_i <= L_ONE) ? ST_DONE : ST_PRE_RD;
                end
            end
            ST_PRE_RD: begin
                offset_o = L_ZERO;
                r_d.st   = ST_PRE_WT;
            end
            ST_PRE_WT: begin
                r_d.carry = rdata_i;
                r_d.st    = ST_RD;
            end
            ST_RD: begin
                offset_o = j_next;
                r_d.st   = ST_CMP;
            end
            ST_CMP: begin
                r_d.carry = hi_i;
                r_d.low   = lo_i;
                if (swap_i) begin
                    r_d.st = ST_WR_LO;
                end else if (!last_step) begin
                    r_d.j  = j_next;
                    r_d.st = ST_RD;
                end else if (!last_pass) begin
                    r_d.j    = L_ZERO;
                    r_d.pass = r_q.pass + L_ONE;
                    r_d.st   = ST_PRE_RD;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            ST_WR_LO: begin
                offset_o = r_q.j;
                we_o     = 1'b1;
                wdata_o  = r_q.low;
                r_d.st   = ST_WR_HI;
            end
            ST_WR_HI: begin
                offset_o = j_next;
                we_o     = 1'b1;
                wdata_o  = r_q.carry;
                if (!last_step) begin
                    r_d.j  = j_next;
                    r_d.st = ST_RD;
                end else if (!last_pass) begin
                    r_d.j    = L_ZERO;
                    r_d.pass = r_q.pass + L_ONE;
                    r_d.st   = ST_PRE_RD;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign carry_o = r_q.carry;
    assign base_o  = r_q.base;
    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = (r_q.st == ST_DONE);

endmodule

// File: rtl/bsort_engine.sv
module bsort_engine #(
    parameter int DATA_W  = 32,
    parameter int MAX_LEN = 256,
    parameter int ADDR_W  = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    logic signed [DATA_W-1:0] carry;
    logic signed [DATA_W-1:0] lo;
    logic signed [DATA_W-1:0] hi;
    logic signed [DATA_W-1:0] wdata;
    logic                     swap;
    logic [ADDR_W-1:0]        base_q;
    logic [LEN_W-1:0]         offset;
    logic                     busy;

    bsort_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .base_i   (base_i),
        .len_i    (len_i),
        .rdata_i  (mem_rdata_i),
        .swap_i   (swap),
        .lo_i     (lo),
        .hi_i     (hi),
        .carry_o  (carry),
        .base_o   (base_q),
        .offset_o (offset),
        .we_o     (mem_we_o),
        .wdata_o  (wdata),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    bsort_cmp #(.DATA_W(DATA_W)) cmp_i (
        .carry_i   (carry),
        .fetched_i (mem_rdata_i),
        .swap_o    (swap),
        .lo_o      (lo),
        .hi_o      (hi)
    );

    bsort_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) addr_i (
        .base_i   (base_q),
        .offset_i (offset),
        .addr_o   (mem_addr_o)
    );

    assign mem_wdata_o = wdata;

endmodule

// File: rtl/bsort_checker.sv
module bsort_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              busy,
    input logic              done_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && len_i <= LEN_W'(1)) |=> (done_o && !mem_we_o)); // R5

    AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R3

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> ($signed($past(mem_wdata_o)) < $signed(mem_wdata_o))); // R3

    AST_WRITE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |=> !mem_we_o); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_we_o); // R2

endmodule

bind bsort_engine bsort_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .busy        (busy),
    .done_o      (done_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/bsort_engine_tb_top.sv
`timescale 1ns/1ps
module bsort_engine_tb_top;
    localparam int DATA_W  = 8;
    localparam int MAX_LEN = 16;
    localparam int ADDR_W  = 5;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [LEN_W-1:0]  len_i = '0;
    logic              done_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_we_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic [DATA_W-1:0] mem_rdata_i;

    always #2.5 clk = ~clk;

    bsort_engine #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
        .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    logic [DATA_W-1:0] mem [DEPTH];
    int n_writes = 0;
    int n_stray  = 0;
    int reg_lo   = 0;
    int reg_len  = 0;

    always @(posedge clk) begin
        mem_rdata_i <= mem[mem_addr_o];
        if (mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            n_writes = n_writes + 1;
            if (((int'(mem_addr_o) - reg_lo + DEPTH) % DEPTH) >= reg_len) n_stray = n_stray + 1;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    logic signed [DATA_W-1:0] src [MAX_LEN];

    task automatic run_sort(input int base, input int n, input int poke);
        logic signed [DATA_W-1:0] exp_v [MAX_LEN];
        logic [DATA_W-1:0] guard [DEPTH];
        int inv = 0;
        int k = 0;
        int exp_k;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a] = DATA_W'(a * 37 + 5);
        end
        for (int i = 0; i < n; i++) mem[(base + i) % DEPTH] = src[i];
        for (int a = 0; a < DEPTH; a++) guard[a] = mem[a];
        for (int i = 0; i < n; i++) exp_v[i] = src[i];
        for (int i = 0; i < n; i++)
            for (int m = i + 1; m < n; m++)
                if (src[i] > src[m]) inv++;
        for (int i = 1; i < n; i++)
            for (int m = i; m > 0 && exp_v[m-1] > exp_v[m]; m--) begin
                logic signed [DATA_W-1:0] t;
                t = exp_v[m]; exp_v[m] = exp_v[m-1]; exp_v[m-1] = t;
            end
        exp_k = (n <= 1) ? 0 : n * 2 * (n - 1) + 2 * inv;
        reg_lo = base; reg_len = n; n_writes = 0; n_stray = 0;
        @(negedge clk);
        start_i = 1'b1; base_i = ADDR_W'(base); len_i = LEN_W'(n);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && k < 5000) begin
            k++;
            if (poke > 0 && k == poke) begin
                start_i = 1'b1; base_i = ADDR_W'(base + 3); len_i = LEN_W'(2);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (k >= 5000) chk("R4 watchdog", k, exp_k);
        chk(poke > 0 ? "R7 latency" : "R4 latency", k, exp_k);
        chk(n <= 1 ? "R5 writes" : "R3 writes", n_writes, 2 * inv);
        chk("R8 stray writes", n_stray, 0);
        for (int i = 0; i < n; i++)
            chk("R2 order", int'($signed(mem[(base + i) % DEPTH])), int'(exp_v[i]));
        for (int a = 0; a < DEPTH; a++)
            if (((a - base + DEPTH) % DEPTH) >= n) chk("R8 outside", int'(mem[a]), int'(guard[a]));
        @(negedge clk);
        chk("R6 pulse width", int'(done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 we after reset", int'(mem_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done idle", int'(done_o), 0);

        // R5: empty and single-element runs
        src[0] = 8'sd9;
        run_sort(4, 0, 0);
        run_sort(4, 1, 0);

        // R2 R3 R4: exhaustive over four elements from {-2,0,2}
        for (int code = 0; code < 81; code++) begin
            int c = code;
            for (int i = 0; i < 4; i++) begin
                src[i] = DATA_W'((c % 3) * 2 - 2);
                c = c / 3;
            end
            run_sort(code % DEPTH, 4, 0);
        end

        // R2 R4: lengths 2..MAX_LEN, descending, ascending, equal, pseudo-random
        for (int n = 2; n <= MAX_LEN; n++) begin
            for (int i = 0; i < n; i++) src[i] = DATA_W'(60 - 9 * i);
            run_sort(20, n, 0);
            for (int i = 0; i < n; i++) src[i] = DATA_W'(-70 + 9 * i);
            run_sort(1, n, 0);
            for (int i = 0; i < n; i++) src[i] = -8'sd5;
            run_sort(7, n, 0);
            for (int i = 0; i < n; i++) src[i] = DATA_W'((i * 101 + n * 53) % 256);
            run_sort(n, n, 0);
        end

        // R7: start pulse mid-run is ignored; R8: wrap past top of address space
        for (int i = 0; i < 6; i++) src[i] = DATA_W'(i * 45 - 120 + (i % 2) * 90);
        run_sort(29, 6, 7);
        run_sort(12, 6, 20);

        finish_up();
    end
endmodule